// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Acknowledge

This block collects interrupt requests from a set of numbered sources and presents the most urgent one to a single processor. The priority range is inverted: a smaller priority number is more urgent. Each source has a sticky pending flag, an enable, a group bit and an 8-bit priority. A distributor holds the per-source state and two group enables. A CPU-facing interface holds a signalling enable, a priority mask, an acknowledge register and an end-of-interrupt register. Pending flags are set by a hardware line per source or by software.

Software reads the acknowledge register to claim the winning source. That read returns the source number and moves the source from pending to active. Software later writes the same number to the end-of-interrupt register. While sources are active, only a strictly more urgent source can interrupt. The running level is always the most urgent of the active sources, so retiring one restores the level that was in force before it.

All registers sit on a 32-bit bus with word addresses. Address bit 12 selects the CPU side (1) or the distributor (0). Read data is registered and appears one cycle after the read is taken.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_o is low and every register reads zero. The acknowledge register (CPU offset 0x00C) reads 1023.
- R2: Among eligible sources, the lowest priority value wins. For example, 0x20 beats 0x40, and 0x40 beats 0x80. Equal priorities resolve to the lower source number.
- R3: A source is signalled only when its priority is strictly below the mask held in bits [7:0] of CPU offset 0x004. A priority equal to the mask is not signalled.
- R4: Distributor offset 0x000 bit 0 enables group 0 and bit 1 enables group 1. A source's group bit is bit (id mod 32) of distributor word 0x080 + 4*(id/32). A source in a disabled group is never signalled.
- R5: CPU offset 0x000 bit 0 enables signalling. While it is clear, irq_o is low and an acknowledge read returns 1023 without changing any state.
- R6: An acknowledge read returns the winning source number in bits [9:0] and zero elsewhere. It clears that source's pending flag and makes the source active. An active source is not signalled again until it is retired, even if it becomes pending again.
- R7: An acknowledge read while nothing is signalled returns 1023 and leaves all pending and active state unchanged.
- R8: Writing a source number to CPU offset 0x010 clears that source's active state. A number outside the implemented range has no effect.
- R9: While sources are active, only a source whose priority is strictly below the lowest active priority is signalled. Retiring an interrupt restores the previous running level.
- R10: Writing ones to the set banks sets flags; writing ones to the clear banks clears them. Pending uses set 0x200 + 4k and clear 0x280 + 4k. Enable uses set 0x100 + 4k and clear 0x180 + 4k. In each bank, bit (id mod 32) of word k = id/32 belongs to the source. Either address of a bank reads back the current flags. Several sources can be made pending in one write.
- R11: A high level on src_in[id] in a cycle sets that source's pending flag. If this happens in the same cycle that the source is acknowledged, the source ends up both active and pending.
- R12: irq_o is a level output. It is high exactly while a signalled source exists, and it reflects register writes from the cycle after the write.
- R13: Priorities are packed four to a word from distributor offset 0x400. Byte b of word 0x400 + 4n belongs to source 4n + b, and the word reads back as written.
- R14: Read data appears on bus_rdata in the cycle after the read is taken and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | NUM_IRQ | Per-source request lines; a high cycle sets pending |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address; bit 12 selects the CPU side |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request level to the processor |

## Verification
Two functions can act on the same source in the same clock edge. An acknowledge read clears that source's pending flag, and a high source line sets it. The bench provokes this by raising src_in for the exact cycle in which the acknowledge read of that source is taken. It judges the outcome at the ports: the acknowledge returns the source number, the pending bank reads the flag back as set, irq_o stays low while the source is active, and the source is signalled again once it is retired.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam int ADDR_W = 13;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic              vld;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } cand_t;

  // lo holds the lower source numbers; it wins ties
  function automatic cand_t pick(cand_t lo, cand_t hi);
    if (!hi.vld)                 return lo;
    else if (!lo.vld)            return hi;
    else if (hi.prio < lo.prio)  return hi;
    else                         return lo;
  endfunction
endpackage

// File: rtl/pic_prio_tree.sv
module pic_prio_tree
  import pic_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N-1:0]             req,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output cand_t                    best
);
  localparam int LV = (N < 2) ? 1 : $clog2(N);
  localparam int P  = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int W = 1 << (LV - l);
    cand_t n [W];
    for (genvar j = 0; j < W; j++) begin : g_n
      if (l == 0) begin : g_leaf
        if (j < N) begin : g_real
          assign n[j] = {req[j], ID_W'(j), prio[j]};
        end else begin : g_pad
          assign n[j] = '0;
        end
      end else begin : g_merge
        assign n[j] = pick(g_lv[l-1].n[2*j], g_lv[l-1].n[2*j+1]);
      end
    end
  end

  assign best = g_lv[LV].n[0];
endmodule

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
#(
  parameter int N = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             src_in,
  input  logic                     dwr,
  input  logic [9:0]               waddr,
  input  logic [31:0]              wdata,
  input  logic                     ack_fire,
  input  logic [ID_W-1:0]          ack_id,
  input  logic                     eoi_fire,
  input  logic [ID_W-1:0]          eoi_id,
  output logic [N-1:0]             pend,
  output logic [N-1:0]             enab,
  output logic [N-1:0]             act,
  output logic [N-1:0][PRIO_W-1:0] prio,
  output logic [N-1:0]             elig,
  output logic [31:0]              rdata
);
  localparam int NW  = N / 32;
  localparam int NPW = N / 4;
  localparam int BIW = (NW > 1) ? $clog2(NW) : 1;
  localparam int PIW = $clog2(NPW);

  localparam logic [4:0] RG_GRP = 5'd1;
  localparam logic [4:0] RG_ENS = 5'd2;
  localparam logic [4:0] RG_ENC = 5'd3;
  localparam logic [4:0] RG_PS  = 5'd4;
  localparam logic [4:0] RG_PC  = 5'd5;

  logic [1:0]   gen_q, gen_n;
  logic [N-1:0] grp_q, grp_n, en_q, en_n, pend_q, pend_n, act_q, act_n;
  logic [NPW-1:0][31:0] prio_q, prio_n;

  logic       is_prio, is_ctrl;
  logic [4:0] reg_sel, bank;
  logic [7:0] word8;
  assign is_prio = (waddr[9:8] == 2'b01);
  assign is_ctrl = (waddr == 10'd0);
  assign reg_sel = waddr[9:5];
  assign bank    = waddr[4:0];
  assign word8   = waddr[7:0];

  logic [N-1:0] ack_oh, eoi_oh;
  assign ack_oh = ack_fire ? (N'(1) << ack_id) : '0;
  assign eoi_oh = eoi_fire ? (N'(1) << eoi_id) : '0;

  logic [NW-1:0] we_grp, we_ens, we_enc, we_ps, we_pc;
  for (genvar k = 0; k < NW; k++) begin : g_bank
    logic hit;
    assign hit       = dwr & ~is_prio & (bank == 5'(k));
    assign we_grp[k] = hit & (reg_sel == RG_GRP);
    assign we_ens[k] = hit & (reg_sel == RG_ENS);
    assign we_enc[k] = hit & (reg_sel == RG_ENC);
    assign we_ps[k]  = hit & (reg_sel == RG_PS);
    assign we_pc[k]  = hit & (reg_sel == RG_PC);
  end

  assign gen_n = (dwr & is_ctrl) ? wdata[1:0] : gen_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int K = i / 32;
    localparam int B = i % 32;
    assign grp_n[i]  = we_grp[K] ? wdata[B] : grp_q[i];
    assign en_n[i]   = (en_q[i] | (we_ens[K] & wdata[B])) & ~(we_enc[K] & wdata[B]);
    assign pend_n[i] = (pend_q[i] & ~(we_pc[K] & wdata[B]) & ~ack_oh[i])
                       | src_in[i] | (we_ps[K] & wdata[B]);
    assign act_n[i]  = (act_q[i] | ack_oh[i]) & ~eoi_oh[i];
    assign elig[i]   = pend_q[i] & en_q[i] & ~act_q[i] & gen_q[grp_q[i]];
  end

  for (genvar w = 0; w < NPW; w++) begin : g_pw
    logic pwe;
    assign pwe       = dwr & is_prio & (word8 == 8'(w));
    assign prio_n[w] = pwe ? wdata : prio_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= '0;
      grp_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      prio_q <= '0;
    end else begin
      gen_q  <= gen_n;
      grp_q  <= grp_n;
      en_q   <= en_n;
      pend_q <= pend_n;
      act_q  <= act_n;
      prio_q <= prio_n;
    end
  end

  assign pend = pend_q;
  assign enab = en_q;
  assign act  = act_q;
  assign prio = prio_q;

  logic [NW-1:0][31:0] grp_w, en_w, pend_w;
  assign grp_w  = grp_q;
  assign en_w   = en_q;
  assign pend_w = pend_q;

  always_comb begin
    rdata = '0;
    if (is_prio) begin
      if (word8 < 8'(NPW)) rdata = prio_q[word8[PIW-1:0]];
    end else if (is_ctrl) begin
      rdata = {30'b0, gen_q};
    end else if (bank < 5'(NW)) begin
      case (reg_sel)
        RG_GRP:         rdata = grp_w[bank[BIW-1:0]];
        RG_ENS, RG_ENC: rdata = en_w[bank[BIW-1:0]];
        RG_PS, RG_PC:   rdata = pend_w[bank[BIW-1:0]];
        default:        rdata = '0;
      endcase
    end
  end

  // R6: a claimed source is active on the following cycle
  p_ack_marks_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (act_q & $past(ack_oh)) != '0);

  // R8: a retired source is no longer active
  p_eoi_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> (act_q & $past(eoi_oh)) == '0);

  // R11: a request line always leaves its pending flag set, even against a claim
  p_src_latches_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in != '0) |=> (pend_q & $past(src_in)) == $past(src_in));
endmodule

// File: rtl/pic_cpu_if.sv
module pic_cpu_if
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cwr,
  input  logic            crd,
  input  logic [9:0]      waddr,
  input  logic [9:0]      wdata,
  input  cand_t           win,
  input  cand_t           run,
  output logic            irq_o,
  output logic            ack_fire,
  output logic [ID_W-1:0] ack_id,
  output logic            eoi_fire,
  output logic [ID_W-1:0] eoi_id,
  output logic [31:0]     rdata
);
  localparam logic [9:0] W_CTRL = 10'd0;
  localparam logic [9:0] W_PMR  = 10'd1;
  localparam logic [9:0] W_ACK  = 10'd3;
  localparam logic [9:0] W_EOI  = 10'd4;

  logic              en_q, en_n;
  logic [PRIO_W-1:0] pmr_q, pmr_n;
  logic [PRIO_W:0]   run_lim;
  logic              signal;

  assign en_n  = (cwr && waddr == W_CTRL) ? wdata[0] : en_q;
  assign pmr_n = (cwr && waddr == W_PMR)  ? wdata[PRIO_W-1:0] : pmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pmr_q <= '0;
    end else begin
      en_q  <= en_n;
      pmr_q <= pmr_n;
    end
  end

  assign run_lim  = run.vld ? {1'b0, run.prio} : {1'b1, {PRIO_W{1'b0}}};
  assign signal   = en_q & win.vld & (win.prio < pmr_q) & ({1'b0, win.prio} < run_lim);
  assign irq_o    = signal;
  assign ack_fire = crd & (waddr == W_ACK) & signal;
  assign ack_id   = win.id;
  assign eoi_fire = cwr & (waddr == W_EOI);
  assign eoi_id   = wdata;

  always_comb begin
    case (waddr)
      W_CTRL:  rdata = {31'b0, en_q};
      W_PMR:   rdata = {{(32-PRIO_W){1'b0}}, pmr_q};
      W_ACK:   rdata = {{(32-ID_W){1'b0}}, (signal ? win.id : SPURIOUS_ID)};
      default: rdata = '0;
    endcase
  end

  // R9: after a claim, the claimed source sets the running level
  p_ack_becomes_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> run.vld && run.id == $past(ack_id));

  // R9: after a claim, only a strictly more urgent source may be signalled
  p_preempt_strict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_o || (win.prio < $past(win.prio)));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] src_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic       acc, rd, cpu_side;
  logic [9:0] waddr;
  assign acc      = bus_sel & (bus_addr[1:0] == 2'b00);
  assign rd       = acc & ~bus_wr;
  assign cpu_side = bus_addr[12];
  assign waddr    = bus_addr[11:2];

  logic [NUM_IRQ-1:0]             pend, enab, act, elig;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
  logic [31:0]                    dist_rd, cpu_rd;
  logic                           ack_fire, eoi_fire;
  logic [ID_W-1:0]                ack_id, eoi_id;
  cand_t                          win, run;

  pic_src_bank #(.N(NUM_IRQ)) u_bank (
    .clk      (clk),
    .rst_n    (rst_i),
    .src_in   (src_in),
    .dwr      (acc & bus_wr & ~cpu_side),
    .waddr    (waddr),
    .wdata    (bus_wdata),
    .ack_fire (ack_fire),
    .ack_id   (ack_id),
    .eoi_fire (eoi_fire),
    .eoi_id   (eoi_id),
    .pend     (pend),
    .enab     (enab),
    .act      (act),
    .prio     (prio),
    .elig     (elig),
    .rdata    (dist_rd)
  );

  pic_prio_tree #(.N(NUM_IRQ)) u_pend_tree (
    .req  (elig),
    .prio (prio),
    .best (win)
  );

  pic_prio_tree #(.N(NUM_IRQ)) u_act_tree (
    .req  (act),
    .prio (prio),
    .best (run)
  );

  pic_cpu_if u_cpu (
    .clk      (clk),
    .rst_n    (rst_i),
    .cwr      (acc & bus_wr & cpu_side),
    .crd      (rd & cpu_side),
    .waddr    (waddr),
    .wdata    (bus_wdata[ID_W-1:0]),
    .win      (win),
    .run      (run),
    .irq_o    (irq_o),
    .ack_fire (ack_fire),
    .ack_id   (ack_id),
    .eoi_fire (eoi_fire),
    .eoi_id   (eoi_id),
    .rdata    (cpu_rd)
  );

  logic [31:0] rdata_q, rdata_n;
  assign rdata_n = rd ? (cpu_side ? cpu_rd : dist_rd) : rdata_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end
  assign bus_rdata = rdata_q;

  logic ack_read;
  assign ack_read = rd & cpu_side & (waddr == 10'd3);

  // R7: an unanswered claim leaves the active set untouched
  p_spurious_quiet_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (ack_read && !irq_o) |=> $stable(act));

  // R12: the request level implies a source that the distributor deems eligible
  p_irq_has_candidate_r12: assert property (@(posedge clk) disable iff (!rst_i)
    irq_o |-> (elig != '0) && ((pend & enab & ~act) != '0));
endmodule

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  localparam int N = 64;
  localparam logic [12:0] CPU = 13'h1000;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src_in;
  logic          bus_sel, bus_wr;
  logic [12:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic rd_seen;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  prio_intc #(.NUM_IRQ(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= bus_sel & ~bus_wr;

  always @(negedge clk) begin : monitor
    logic [31:0] e;
    string t;
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R14: read data %h with no expected item", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (bus_rdata !== e) begin
          miscompares++;
          $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_src(input logic [12:0] a, input logic [31:0] e, input string t,
                        input int idx);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    src_in[idx] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0;
    src_in = '0;
  endtask

  task automatic pulse_src(input int idx);
    @(negedge clk);
    src_in[idx] = 1'b1;
    @(negedge clk);
    src_in = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    vectors++;
    if (irq_o !== e) begin
      miscompares++;
      $display("FAIL %s: irq_o %b expected %b", t, irq_o, e);
    end
  endtask

  function automatic logic [31:0] id32(input int id);
    return 32'(id);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(CPU + 13'h00C, 32'd1023, "R1 ack reads 1023 after reset");
    rd(CPU + 13'h004, 32'h0, "R1 mask reset");
    rd(13'h000, 32'h0, "R1 distributor control reset");
    rd(13'h420, 32'h0, "R1 priority word reset");

    // configuration: id34 0x20, id33 0x40, id27 0x80
    wr(13'h000, 32'h3);
    wr(CPU + 13'h000, 32'h1);
    wr(CPU + 13'h004, 32'hF0);
    wr(13'h420, 32'h0020_4000);
    wr(13'h418, 32'h8000_0000);
    rd(13'h420, 32'h0020_4000, "R13 priority packing readback");
    wr(13'h100, 32'h0800_0000);
    wr(13'h104, 32'h0000_0006);
    wr(13'h084, 32'h0000_0006);
    rd(13'h104, 32'h6, "R10 enable readback");
    chk_irq(1'b0, "R12 nothing pending");

    // R10 several pending at once, R2 ordering, R9 nesting
    wr(13'h200, 32'h0800_0000);
    wr(13'h204, 32'h0000_0006);
    rd(13'h204, 32'h6, "R10 pending readback");
    chk_irq(1'b1, "R12 eligible source raises irq");
    rd(CPU + 13'h00C, id32(34), "R2 most urgent first (34)");
    chk_irq(1'b0, "R9 less urgent blocked while 34 active");
    rd(CPU + 13'h00C, 32'd1023, "R7 spurious while blocked");
    rd(13'h204, 32'h2, "R6 claim cleared pending of 34 only");
    wr(CPU + 13'h010, id32(34));
    chk_irq(1'b1, "R9 retire restores level");
    rd(CPU + 13'h00C, id32(33), "R2 second (33)");
    rd(CPU + 13'h00C, 32'd1023, "R9 27 not above running 0x40");
    wr(CPU + 13'h010, id32(33));
    rd(CPU + 13'h00C, id32(27), "R2 third (27)");
    wr(CPU + 13'h010, id32(27));
    chk_irq(1'b0, "R8 all retired");

    // R3 mask strictness
    wr(CPU + 13'h004, 32'h80);
    wr(13'h200, 32'h0800_0000);
    chk_irq(1'b0, "R3 priority equal to mask");
    rd(CPU + 13'h00C, 32'd1023, "R3 equal to mask not claimable");
    wr(CPU + 13'h004, 32'h81);
    chk_irq(1'b1, "R3 priority below mask");
    rd(CPU + 13'h00C, id32(27), "R3 claim 27");
    wr(CPU + 13'h010, id32(27));

    // R4 group enables
    wr(13'h000, 32'h1);
    wr(13'h204, 32'h2);
    chk_irq(1'b0, "R4 group 1 disabled");
    wr(13'h000, 32'h3);
    chk_irq(1'b1, "R4 group 1 enabled");
    rd(CPU + 13'h00C, id32(33), "R4 claim 33");
    wr(CPU + 13'h010, id32(33));
    wr(13'h000, 32'h2);
    wr(13'h200, 32'h0800_0000);
    chk_irq(1'b0, "R4 group 0 disabled");
    wr(13'h000, 32'h3);
    chk_irq(1'b1, "R4 group 0 enabled");
    rd(CPU + 13'h00C, id32(27), "R4 claim 27");
    wr(CPU + 13'h010, id32(27));

    // R2 tie goes to lower id
    wr(13'h428, 32'h0000_0040);
    wr(13'h104, 32'h0000_0100);
    wr(13'h204, 32'h0000_0102);
    rd(CPU + 13'h00C, id32(33), "R2 tie lower id");
    wr(CPU + 13'h010, id32(33));
    rd(CPU + 13'h00C, id32(40), "R2 tie then 40");
    wr(CPU + 13'h010, id32(40));

    // R5 CPU enable
    wr(13'h200, 32'h0800_0000);
    wr(CPU + 13'h000, 32'h0);
    chk_irq(1'b0, "R5 signalling disabled");
    rd(CPU + 13'h00C, 32'd1023, "R5 claim while disabled");
    rd(13'h200, 32'h0800_0000, "R5 pending kept");
    wr(CPU + 13'h000, 32'h1);
    chk_irq(1'b1, "R5 signalling enabled");
    rd(CPU + 13'h00C, id32(27), "R5 claim 27");

    // R6 pending while active, R8 out-of-range retire
    wr(13'h200, 32'h0800_0000);
    chk_irq(1'b0, "R6 active source not re-signalled");
    wr(CPU + 13'h010, 32'd1023);
    chk_irq(1'b0, "R8 out-of-range retire ignored");
    wr(CPU + 13'h010, id32(27));
    chk_irq(1'b1, "R8 retire lets pending 27 through");
    rd(CPU + 13'h00C, id32(27), "R6 claim 27 again");
    wr(CPU + 13'h010, id32(27));

    // R11 source line in the same cycle as the claim
    wr(13'h204, 32'h2);
    rd_src(CPU + 13'h00C, id32(33), "R11 claim with line high", 33);
    rd(13'h204, 32'h2, "R11 pending survives claim");
    chk_irq(1'b0, "R11 active and pending not signalled");
    wr(CPU + 13'h010, id32(33));
    chk_irq(1'b1, "R11 re-signalled after retire");
    rd(CPU + 13'h00C, id32(33), "R11 second claim");
    wr(CPU + 13'h010, id32(33));
    chk_irq(1'b0, "R11 quiet");

    // R11 line alone, R10 clear banks
    pulse_src(27);
    chk_irq(1'b1, "R11 line sets pending");
    rd(13'h200, 32'h0800_0000, "R11 pending from line");
    wr(13'h280, 32'h0800_0000);
    chk_irq(1'b0, "R10 pending cleared");
    rd(13'h280, 32'h0, "R10 pending reads zero");
    wr(13'h180, 32'h0800_0000);
    rd(13'h100, 32'h0, "R10 enable cleared");
    wr(13'h200, 32'h0800_0000);
    chk_irq(1'b0, "R10 disabled source not signalled");
    rd(13'h200, 32'h0800_0000, "R10 pending while disabled");
    rd(CPU + 13'h004, 32'h81, "R14 mask readback");
    rd(13'h000, 32'h3, "R4 control readback");

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule